// File: doc/BRIEF.md
# Dual Interrupt Controller Merge Arbiter

Two identical interrupt controller instances are needed when a chip carries more interrupt sources than one controller can rank uniquely. Each instance reports its best pending request as a valid flag, a level, a priority slot within that level and a vector. This block compares the two reports and presents a single winner to the processor as a merged level and a vector.

The winner is found by comparing the level first and then the priority slot. Instance 1 is chosen only when it is strictly ahead. When the processor raises its acknowledge strobe, the winning instance, level and vector are captured and held for as long as the strobe stays high. The acknowledge goes to the winning instance alone, so the request of the other instance stays pending and competes again later. Each instance ranks within 7 levels, with 9 priority slots per level. Slot 0 is the lowest and slot 8 the highest.

Top module: `irq_merge_arb`

## Requirements
- R1: When neither instance is valid and no acknowledge is held, the merged level is 0 and the vector is 0.
- R2: When exactly one instance is valid, its level and vector are presented, whatever the other instance's fields hold.
- R3: With both valid, the instance with the higher level wins, whatever the slots are.
- R4: With both valid at the same level, the instance with the higher slot wins.
- R5: With both valid at an identical level and slot, instance 0 wins.
- R6: While the acknowledge strobe is high, only the selected instance's acknowledge line is high. The two acknowledge lines are never high together, and neither is high without the strobe.
- R7: From the cycle after the strobe rises until it falls, the merged level, the vector and the acknowledge lines stay at the values captured on the first cycle, even when the instance inputs change.
- R8: A strobe that arrives while neither instance is valid forwards no acknowledge, and the level and vector stay 0 for the whole strobe.
- R9: In the cycle after the strobe falls, the outputs follow the live instance inputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| c0_valid | input | 1 | Instance 0 has a pending request |
| c0_level | input | 3 | Instance 0 best level |
| c0_slot | input | 4 | Instance 0 priority slot within its level |
| c0_vector | input | 8 | Instance 0 vector |
| c1_valid | input | 1 | Instance 1 has a pending request |
| c1_level | input | 3 | Instance 1 best level |
| c1_slot | input | 4 | Instance 1 priority slot within its level |
| c1_vector | input | 8 | Instance 1 vector |
| ack_req | input | 1 | Acknowledge strobe from the processor, held high for the cycle |
| irq_level | output | 3 | Merged level presented to the processor |
| irq_vector | output | 8 | Vector of the selected request |
| c0_ack | output | 1 | Acknowledge forwarded to instance 0 |
| c1_ack | output | 1 | Acknowledge forwarded to instance 1 |

## Verification
The hardest situation to reach is an instance input that changes while an acknowledge is being held. At that point the live comparison would choose a different winner than the captured one. The stimulus raises the strobe while instance 1 leads, and on the next cycle gives instance 0 a higher level and a new vector. The bench then checks that the held outputs and the acknowledge routing keep the captured winner. After the strobe drops, it checks that the new winner appears.

// File: rtl/irq_merge_arb.sv
module irq_merge_arb #(
  parameter int LVL_W  = 3,
  parameter int SLOT_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c0_valid,
  input  logic [LVL_W-1:0]  c0_level,
  input  logic [SLOT_W-1:0] c0_slot,
  input  logic [VEC_W-1:0]  c0_vector,
  input  logic              c1_valid,
  input  logic [LVL_W-1:0]  c1_level,
  input  logic [SLOT_W-1:0] c1_slot,
  input  logic [VEC_W-1:0]  c1_vector,
  input  logic              ack_req,
  output logic [LVL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              c0_ack,
  output logic              c1_ack
);
  localparam int KEY_W = LVL_W + SLOT_W;

  logic [KEY_W-1:0] key0, key1;
  logic             live_pick1, live_any;
  logic [LVL_W-1:0] live_level;
  logic [VEC_W-1:0] live_vector;

  logic             held_q, pick1_q, any_q;
  logic [LVL_W-1:0] level_q;
  logic [VEC_W-1:0] vector_q;
  logic             hold;
  logic             pick1, any_v;

  assign key0 = {c0_level, c0_slot};
  assign key1 = {c1_level, c1_slot};

  assign live_any   = c0_valid | c1_valid;
  assign live_pick1 = c1_valid & (~c0_valid | (key1 > key0));

  assign live_level  = !live_any  ? '0 : (live_pick1 ? c1_level  : c0_level);
  assign live_vector = !live_any  ? '0 : (live_pick1 ? c1_vector : c0_vector);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      pick1_q  <= 1'b0;
      any_q    <= 1'b0;
      level_q  <= '0;
      vector_q <= '0;
    end else begin
      held_q <= ack_req;
      if (ack_req && !held_q) begin
        pick1_q  <= live_pick1;
        any_q    <= live_any;
        level_q  <= live_level;
        vector_q <= live_vector;
      end
    end
  end

  assign hold  = ack_req & held_q;
  assign pick1 = hold ? pick1_q : live_pick1;
  assign any_v = hold ? any_q   : live_any;

  assign irq_level  = hold ? level_q  : live_level;
  assign irq_vector = hold ? vector_q : live_vector;

  assign c0_ack = ack_req & any_v & ~pick1;
  assign c1_ack = ack_req & any_v &  pick1;
endmodule

module irq_merge_arb_chk #(
  parameter int LVL_W  = 3,
  parameter int SLOT_W = 4,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c0_valid,
  input logic [LVL_W-1:0]  c0_level,
  input logic [SLOT_W-1:0] c0_slot,
  input logic [VEC_W-1:0]  c0_vector,
  input logic              c1_valid,
  input logic [LVL_W-1:0]  c1_level,
  input logic [SLOT_W-1:0] c1_slot,
  input logic              ack_req,
  input logic [LVL_W-1:0]  irq_level,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              c0_ack,
  input logic              c1_ack
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!c0_valid && !c1_valid && !ack_req) |-> (irq_level == '0 && irq_vector == '0)); // R1
  AST_TIE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_req && c0_valid && c1_valid && c0_level == c1_level && c0_slot == c1_slot)
      |-> (irq_vector == c0_vector)); // R5
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c0_ack, c1_ack})); // R6
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_ack || c1_ack) |-> ack_req); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && $past(ack_req)) |-> ($stable(irq_level) && $stable(irq_vector))); // R7
  AST_HOLD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && $past(ack_req)) |-> ($stable(c0_ack) && $stable(c1_ack))); // R7
endmodule

bind irq_merge_arb irq_merge_arb_chk #(.LVL_W(LVL_W), .SLOT_W(SLOT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .c0_valid(c0_valid), .c0_level(c0_level), .c0_slot(c0_slot), .c0_vector(c0_vector),
  .c1_valid(c1_valid), .c1_level(c1_level), .c1_slot(c1_slot),
  .ack_req(ack_req), .irq_level(irq_level), .irq_vector(irq_vector),
  .c0_ack(c0_ack), .c1_ack(c1_ack)
);

// File: tb/irq_merge_arb_tb.sv
module irq_merge_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c0_valid = 1'b0, c1_valid = 1'b0, ack_req = 1'b0;
  logic [2:0] c0_level = '0, c1_level = '0, irq_level;
  logic [3:0] c0_slot = '0, c1_slot = '0;
  logic [7:0] c0_vector = '0, c1_vector = '0, irq_vector;
  logic       c0_ack, c1_ack;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_merge_arb u_dut (
    .clk(clk), .rst_n(rst_n),
    .c0_valid(c0_valid), .c0_level(c0_level), .c0_slot(c0_slot), .c0_vector(c0_vector),
    .c1_valid(c1_valid), .c1_level(c1_level), .c1_slot(c1_slot), .c1_vector(c1_vector),
    .ack_req(ack_req), .irq_level(irq_level), .irq_vector(irq_vector),
    .c0_ack(c0_ack), .c1_ack(c1_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set0(input logic v, input int l, input int s, input int vec);
    c0_valid = v; c0_level = 3'(l); c0_slot = 4'(s); c0_vector = 8'(vec);
  endtask

  task automatic set1(input logic v, input int l, input int s, input int vec);
    c1_valid = v; c1_level = 3'(l); c1_slot = 4'(s); c1_vector = 8'(vec);
  endtask

  task automatic expect_out(input string req, input int l, input int vec, input int a0, input int a1);
    #1;
    chk({req, " level"}, int'(irq_level), l);
    chk({req, " vector"}, int'(irq_vector), vec);
    chk({req, " ack0"}, int'(c0_ack), a0);
    chk({req, " ack1"}, int'(c1_ack), a1);
  endtask

  task automatic t_idle();  // R1
    @(negedge clk); set0(0, 5, 3, 8'h11); set1(0, 6, 2, 8'h22);
    expect_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_single();  // R2
    @(negedge clk); set0(1, 2, 1, 8'h21); set1(0, 7, 8, 8'h78);
    expect_out("R2 only c0", 2, 8'h21, 0, 0);
    @(negedge clk); set0(0, 7, 8, 8'h78); set1(1, 1, 0, 8'h10);
    expect_out("R2 only c1", 1, 8'h10, 0, 0);
  endtask

  task automatic t_level();  // R3
    @(negedge clk); set0(1, 3, 8, 8'h38); set1(1, 4, 0, 8'h40);
    expect_out("R3 c1 higher level", 4, 8'h40, 0, 0);
    @(negedge clk); set0(1, 6, 0, 8'h60); set1(1, 5, 8, 8'h58);
    expect_out("R3 c0 higher level", 6, 8'h60, 0, 0);
  endtask

  task automatic t_slot();  // R4
    @(negedge clk); set0(1, 4, 3, 8'h43); set1(1, 4, 5, 8'h45);
    expect_out("R4 c1 higher slot", 4, 8'h45, 0, 0);
    @(negedge clk); set0(1, 4, 7, 8'h47); set1(1, 4, 6, 8'h46);
    expect_out("R4 c0 higher slot", 4, 8'h47, 0, 0);
  endtask

  task automatic t_tie();  // R5
    @(negedge clk); set0(1, 7, 4, 8'hA0); set1(1, 7, 4, 8'hB0);
    expect_out("R5 tie", 7, 8'hA0, 0, 0);
    @(negedge clk); set0(1, 1, 0, 8'hA1); set1(1, 1, 0, 8'hB1);
    expect_out("R5 tie low", 1, 8'hA1, 0, 0);
  endtask

  task automatic t_ack_route();  // R6
    @(negedge clk); set0(1, 5, 2, 8'h52); set1(1, 3, 6, 8'h36); ack_req = 1'b1;
    expect_out("R6 ack to c0", 5, 8'h52, 1, 0);
    @(negedge clk); ack_req = 1'b0;
    @(negedge clk); set0(1, 2, 2, 8'h22); set1(1, 2, 3, 8'h23); ack_req = 1'b1;
    expect_out("R6 ack to c1", 2, 8'h23, 0, 1);
    @(negedge clk); ack_req = 1'b0;
    expect_out("R6 no strobe", 2, 8'h23, 0, 0);
  endtask

  task automatic t_ack_hold();  // R7, R9
    @(negedge clk); set0(1, 3, 2, 8'h30); set1(1, 5, 1, 8'h51); ack_req = 1'b1;
    expect_out("R7 first cycle", 5, 8'h51, 0, 1);
    @(negedge clk); set0(1, 7, 8, 8'h77);
    expect_out("R7 held after input change", 5, 8'h51, 0, 1);
    @(negedge clk); set1(0, 0, 0, 8'h00);
    expect_out("R7 held second change", 5, 8'h51, 0, 1);
    @(negedge clk); ack_req = 1'b0;
    expect_out("R9 live after release", 7, 8'h77, 0, 0);
  endtask

  task automatic t_ack_empty();  // R8
    @(negedge clk); set0(0, 4, 4, 8'h44); set1(0, 6, 6, 8'h66); ack_req = 1'b1;
    expect_out("R8 empty first", 0, 0, 0, 0);
    @(negedge clk); set0(1, 4, 4, 8'h44);
    expect_out("R8 empty held", 0, 0, 0, 0);
    @(negedge clk); ack_req = 1'b0;
    expect_out("R9 live after empty ack", 4, 8'h44, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    t_idle();
    t_single();
    t_level();
    t_slot();
    t_tie();
    t_ack_route();
    t_ack_hold();
    t_ack_empty();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule